// File: doc/BRIEF.md
# Edge-Masked Vectored Interrupt Controller

This block gathers interrupt events for a small 8-bit processor and turns them into a single request with a vector. There are eight sources:

- a bus-reset strobe from the USB engine
- two free-running timer tap bits
- three endpoint-completion strobes
- a DAC port of input pins
- a group of GPIO ports

Each source owns a sticky pending flag. The flag is set by the source's qualifying event and stays set until the processor accepts that source.

The DAC and GPIO pins arrive from the pads asynchronously, so each passes through a two-stage synchronizer before edge detection. On the DAC port, every pin has its own mask bit and its own edge choice. GPIO pins are masked pin by pin, but the edge choice is made per port, and every GPIO pin feeds one shared vector.

The processor sees one request line and a vector. It accepts an interrupt with an acknowledge strobe and re-enables interrupts with a return strobe. The controller keeps the global enable itself: accepting an interrupt drops it, and the return strobe raises it again.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, `gie` is 0, no source is pending, and `irq_req` stays 0 even once `gie` is raised.
- R2: A timer tap raises its pending flag only on a 0-to-1 change of its bit. Holding the bit high or lowering it raises nothing. Tap 0 is source index 1 and tap 1 is source index 2.
- R3: A DAC pin sets the DAC pending flag (source index 6) only if its `dac_mask` bit is 1. The edge it reacts to is chosen by its `dac_fall` bit: 0 selects rising, 1 selects falling.
- R4: GPIO pin `8*p+b` sets the shared GPIO pending flag (source index 7, vector 14) only if its `gpio_mask` bit is 1. The edge it reacts to is chosen by `gpio_fall_port[p]`: 0 selects rising, 1 selects falling.
- R5: A pending flag stays set until that source is accepted. `src_en[i]` gates only the request, not the latching: a flag set while disabled requests as soon as it is enabled.
- R6: Among pending sources that are enabled, the lowest index wins, and `irq_vec` equals twice that index. The indices are: bus reset 0, taps 1 and 2, endpoints 0 to 2 at 3 to 5, DAC 6, GPIO 7.
- R7: A cycle with `irq_ack` high while `irq_req` is high clears `gie` and the pending flag of the selected source. `irq_ack` without a request has no effect.
- R8: `irq_ret` sets `gie`. If `irq_ret` and an accepted `irq_ack` occur in the same cycle, `gie` ends at 0.
- R9: While `gie` is 0, `irq_req` is 0 whatever is pending.
- R10: A new event for a source, arriving in the same cycle that the source is accepted, leaves its pending flag set.
- R11: A pin change on DAC or GPIO, applied before clock edge k, sets pending at edge k+2 (edges counted from k) and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busrst_evt | input | 1 | Bus-reset event strobe |
| tick_tap | input | 2 | Timer tap bits (fast, slow) |
| ep_evt | input | 3 | Endpoint completion strobes |
| dac_pin | input | 8 | DAC port pins (asynchronous) |
| dac_mask | input | 8 | Per-pin DAC enable |
| dac_fall | input | 8 | Per-pin DAC edge select, 1 = falling |
| gpio_pin | input | 32 | GPIO pins, 4 ports of 8 (asynchronous) |
| gpio_mask | input | 32 | Per-pin GPIO enable |
| gpio_fall_port | input | 4 | Per-port GPIO edge select, 1 = falling |
| src_en | input | 8 | Per-source request enable |
| irq_ack | input | 1 | Processor accepts the current interrupt |
| irq_ret | input | 1 | Return from interrupt, sets global enable |
| irq_req | output | 1 | Interrupt request to processor |
| irq_vec | output | 4 | Vector, twice the source index |
| gie | output | 1 | Global interrupt enable |

## Verification
The hardest situation to reach from the ports is a new event for a source landing in the same cycle that the source is being accepted. The result has to be a flag that survives the acknowledge, not a lost interrupt. Directed stimulus lines up an endpoint strobe with the acknowledge edge and then checks that the same vector is requested again after the return. A random phase fires bursts of strobes with random enables while interrupts are masked, then unmasks them. This builds many mixed pending sets, each of which is checked against a bench-side priority function.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NUM_SRC = 8;
  localparam int SRC_W   = $clog2(NUM_SRC);
  localparam int VEC_W   = SRC_W + 1;

  typedef enum logic [SRC_W-1:0] {
    SRC_BUSRST    = 3'd0,
    SRC_TICK_FAST = 3'd1,
    SRC_TICK_SLOW = 3'd2,
    SRC_EP0       = 3'd3,
    SRC_EP1       = 3'd4,
    SRC_EP2       = 3'd5,
    SRC_DAC       = 3'd6,
    SRC_GPIO      = 3'd7
  } src_e;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q, meta_d;
  logic [W-1:0] stab_q, stab_d;

  always_comb begin
    meta_d = d;
    stab_d = meta_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= meta_d;
      stab_q <= stab_d;
    end
  end

  assign q = stab_q;
endmodule

// File: rtl/irqc_edge.sv
module irqc_edge #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  input  logic [W-1:0] fall_sel,
  input  logic [W-1:0] mask,
  output logic         hit
);
  logic [W-1:0] prev_q, prev_d;
  logic [W-1:0] rise, fall, chosen;

  always_comb begin
    prev_d = d;
    rise   = d & ~prev_q;
    fall   = ~d & prev_q;
    chosen = (fall & fall_sel) | (rise & ~fall_sel);
    hit    = |(chosen & mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  // a hit can only come from a bit that changed since last cycle
  p_hit_needs_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ((d ^ prev_q) & mask) != '0);
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     active,
  output logic             valid,
  output logic [IDX_W-1:0] idx,
  output logic [N-1:0]     grant
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (active[i]) idx = IDX_W'(i);
    end
    valid = |active;
    grant = valid ? (N'(1) << idx) : '0;
  end

  p_grant_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  p_none_higher_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ((active & ((N'(1) << idx) - N'(1))) == '0));
  p_grant_is_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> active[idx]);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqc_pkg::*;
#(
  parameter int DAC_W       = 8,
  parameter int GPIO_PORTS  = 4,
  parameter int GPIO_PORT_W = 8,
  parameter int TAP_N       = 2,
  parameter int EP_N        = 3
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              busrst_evt,
  input  logic [TAP_N-1:0]                  tick_tap,
  input  logic [EP_N-1:0]                   ep_evt,
  input  logic [DAC_W-1:0]                  dac_pin,
  input  logic [DAC_W-1:0]                  dac_mask,
  input  logic [DAC_W-1:0]                  dac_fall,
  input  logic [GPIO_PORTS*GPIO_PORT_W-1:0] gpio_pin,
  input  logic [GPIO_PORTS*GPIO_PORT_W-1:0] gpio_mask,
  input  logic [GPIO_PORTS-1:0]             gpio_fall_port,
  input  logic [NUM_SRC-1:0]                src_en,
  input  logic                              irq_ack,
  input  logic                              irq_ret,
  output logic                              irq_req,
  output logic [VEC_W-1:0]                  irq_vec,
  output logic                              gie
);
  localparam int GPIO_W = GPIO_PORTS * GPIO_PORT_W;

  logic [DAC_W-1:0]   dac_s;
  logic [GPIO_W-1:0]  gpio_s;
  logic [GPIO_W-1:0]  gpio_fall_pin;
  logic [TAP_N-1:0]   tap_hit;
  logic               dac_hit, gpio_hit;
  logic [NUM_SRC-1:0] set_evt;
  logic [NUM_SRC-1:0] pend_q, pend_d;
  logic [NUM_SRC-1:0] active, grant, clr;
  logic               gie_q, gie_d;
  logic               sel_valid, take;
  logic [SRC_W-1:0]   sel_idx;

  irqc_sync #(.W(DAC_W))  u_dac_sync  (.clk(clk), .rst_n(rst_n), .d(dac_pin),  .q(dac_s));
  irqc_sync #(.W(GPIO_W)) u_gpio_sync (.clk(clk), .rst_n(rst_n), .d(gpio_pin), .q(gpio_s));

  irqc_edge #(.W(DAC_W)) u_dac_edge (
    .clk(clk), .rst_n(rst_n), .d(dac_s), .fall_sel(dac_fall),
    .mask(dac_mask), .hit(dac_hit)
  );

  for (genvar p = 0; p < GPIO_PORTS; p++) begin : g_port
    for (genvar b = 0; b < GPIO_PORT_W; b++) begin : g_pin
      assign gpio_fall_pin[p*GPIO_PORT_W+b] = gpio_fall_port[p];
    end
  end

  irqc_edge #(.W(GPIO_W)) u_gpio_edge (
    .clk(clk), .rst_n(rst_n), .d(gpio_s), .fall_sel(gpio_fall_pin),
    .mask(gpio_mask), .hit(gpio_hit)
  );

  for (genvar t = 0; t < TAP_N; t++) begin : g_tap
    irqc_edge #(.W(1)) u_tap_edge (
      .clk(clk), .rst_n(rst_n), .d(tick_tap[t]), .fall_sel(1'b0),
      .mask(1'b1), .hit(tap_hit[t])
    );
  end

  always_comb begin
    set_evt = {gpio_hit, dac_hit, ep_evt, tap_hit, busrst_evt};
    active  = pend_q & src_en & {NUM_SRC{gie_q}};
  end

  irqc_arbiter #(.N(NUM_SRC), .IDX_W(SRC_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .active(active),
    .valid(sel_valid), .idx(sel_idx), .grant(grant)
  );

  always_comb begin
    take   = irq_ack & sel_valid;
    clr    = take ? grant : '0;
    pend_d = (pend_q & ~clr) | set_evt;
    gie_d  = gie_q;
    if (take)         gie_d = 1'b0;
    else if (irq_ret) gie_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      gie_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      gie_q  <= gie_d;
    end
  end

  assign irq_req = sel_valid;
  assign irq_vec = {sel_idx, 1'b0};
  assign gie     = gie_q;

  p_take_drops_gie_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req) |=> !gie);
  p_ret_raises_gie_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ret && !(irq_ack && irq_req)) |=> gie);
  p_masked_gie_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> !irq_req);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[i] && !(take && grant[i])) |=> pend_q[i]);
    p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (take && grant[i] && !set_evt[i]) |=> !pend_q[i]);
    p_new_evt_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt[i] |=> pend_q[i]);
  end
endmodule

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        busrst_evt;
  logic [1:0]  tick_tap;
  logic [2:0]  ep_evt;
  logic [7:0]  dac_pin, dac_mask, dac_fall;
  logic [31:0] gpio_pin, gpio_mask;
  logic [3:0]  gpio_fall_port;
  logic [7:0]  src_en;
  logic        irq_ack, irq_ret;
  logic        irq_req;
  logic [3:0]  irq_vec;
  logic        gie;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_vector_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .busrst_evt(busrst_evt), .tick_tap(tick_tap),
    .ep_evt(ep_evt), .dac_pin(dac_pin), .dac_mask(dac_mask), .dac_fall(dac_fall),
    .gpio_pin(gpio_pin), .gpio_mask(gpio_mask), .gpio_fall_port(gpio_fall_port),
    .src_en(src_en), .irq_ack(irq_ack), .irq_ret(irq_ret),
    .irq_req(irq_req), .irq_vec(irq_vec), .gie(gie)
  );

  function automatic int exp_vec(logic [7:0] act);
    for (int i = 7; i >= 0; i--) ;
    for (int i = 0; i < 8; i++) if (act[i]) return 2 * i;
    return -1;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // request as a single number: -1 none, else vector
  function automatic int seen();
    return irq_req ? int'(irq_vec) : -1;
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_ack();
    irq_ack = 1'b1; tick(1); irq_ack = 1'b0;
  endtask

  task automatic do_ret();
    irq_ret = 1'b1; tick(1); irq_ret = 1'b0;
  endtask

  task automatic pulse_ep(int e);
    ep_evt[e] = 1'b1; tick(1); ep_evt[e] = 1'b0;
  endtask

  task automatic drain();
    src_en = 8'hFF;
    do_ret();
    for (int k = 0; k < 10; k++) begin
      if (irq_req) begin do_ack(); do_ret(); end
    end
  endtask

  logic [7:0] model_pend;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; busrst_evt = 0; tick_tap = 0; ep_evt = 0;
    dac_pin = 0; dac_mask = 0; dac_fall = 0;
    gpio_pin = 0; gpio_mask = 0; gpio_fall_port = 0;
    src_en = 0; irq_ack = 0; irq_ret = 0;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    chk("R1 gie", int'(gie), 0);
    chk("R1 req", seen(), -1);
    src_en = 8'hFF;
    do_ret();
    chk("R1 no pending", seen(), -1);
    irq_ack = 1'b1; tick(1); irq_ack = 1'b0;
    chk("R7 stray ack ignored", int'(gie), 1);

    // R9: masked by global enable
    irq_ack = 1'b1; tick(1); irq_ack = 1'b0;
    busrst_evt = 1'b1; irq_ack = 1'b0; tick(1); busrst_evt = 1'b0;
    chk("R6 busrst vec", seen(), 0);
    do_ack();
    chk("R7 ack drops gie", int'(gie), 0);
    busrst_evt = 1'b1; tick(1); busrst_evt = 1'b0;
    tick(2);
    chk("R9 held while gie low", seen(), -1);
    do_ret();
    chk("R8 ret raises gie", int'(gie), 1);
    chk("R6 busrst after ret", seen(), 0);
    do_ack(); do_ret();
    chk("R7 pending cleared", seen(), -1);

    // R2 timer taps
    tick_tap[0] = 1'b1; tick(1);
    chk("R2 tap0 rise", seen(), 2);
    do_ack(); do_ret(); tick(3);
    chk("R2 tap0 held high", seen(), -1);
    tick_tap[0] = 1'b0; tick(3);
    chk("R2 tap0 fall ignored", seen(), -1);
    tick_tap[1] = 1'b1; tick(1);
    chk("R2 tap1 rise", seen(), 4);
    do_ack(); do_ret(); tick_tap[1] = 1'b0; tick(2);

    // R5 enable gates request, not latching
    src_en = 8'hFF & ~8'h10;
    pulse_ep(1); tick(2);
    chk("R5 disabled source silent", seen(), -1);
    src_en = 8'hFF; tick(1);
    chk("R5 latched while disabled", seen(), 8);
    do_ack(); do_ret();

    // R6 priority across several pending
    do_ack();
    irq_ack = 1'b0;
    drain();
    do_ack(); // nothing pending, ignored
    irq_ack = 1'b0;
    // gie is 1 here; fire with a pending accept to clear gie first
    busrst_evt = 1'b1; tick(1); busrst_evt = 1'b0;
    do_ack();
    chk("R7 gie low for batch", int'(gie), 0);
    ep_evt = 3'b101; tick(1); ep_evt = 3'b000;
    tick_tap[1] = 1'b1; tick(1); tick_tap[1] = 1'b0;
    do_ret(); chk("R6 first tap1", seen(), 4);
    do_ack(); do_ret(); chk("R6 then ep0", seen(), 6);
    do_ack(); do_ret(); chk("R6 then ep2", seen(), 10);
    do_ack(); do_ret(); chk("R6 then none", seen(), -1);

    // R3 / R11 DAC pins
    dac_mask = 8'b0000_0101; dac_fall = 8'b0000_0100;
    dac_pin[0] = 1'b1; tick(2);
    chk("R11 dac not before sync", seen(), -1);
    tick(1);
    chk("R11 R3 dac rise", seen(), 12);
    do_ack(); do_ret();
    dac_pin[1] = 1'b1; tick(5);
    chk("R3 dac masked pin", seen(), -1);
    dac_pin[2] = 1'b1; tick(5);
    chk("R3 dac rise on falling pin", seen(), -1);
    dac_pin[2] = 1'b0; tick(3);
    chk("R3 dac fall on falling pin", seen(), 12);
    do_ack(); do_ret();
    dac_pin[0] = 1'b0; tick(5);
    chk("R3 dac fall on rising pin", seen(), -1);

    // R4 GPIO
    gpio_mask = (32'd1 << 9) | (32'd1 << 20);
    gpio_fall_port = 4'b0100;
    gpio_pin[9] = 1'b1; tick(2);
    chk("R11 gpio not before sync", seen(), -1);
    tick(1);
    chk("R4 gpio port1 rise", seen(), 14);
    do_ack(); do_ret();
    gpio_pin[20] = 1'b1; tick(5);
    chk("R4 gpio port2 rise ignored", seen(), -1);
    gpio_pin[20] = 1'b0; tick(5);
    chk("R4 gpio port2 fall", seen(), 14);
    do_ack(); do_ret();
    gpio_pin[10] = 1'b1; tick(5);
    chk("R4 gpio masked pin", seen(), -1);

    // R10 event coincides with its own accept
    pulse_ep(0);
    chk("R10 ep0 request", seen(), 6);
    irq_ack = 1'b1; ep_evt[0] = 1'b1; tick(1);
    irq_ack = 1'b0; ep_evt[0] = 1'b0;
    chk("R10 gie low", int'(gie), 0);
    do_ret();
    chk("R10 ep0 kept", seen(), 6);

    // R8 ack and ret together
    irq_ack = 1'b1; irq_ret = 1'b1; tick(1);
    irq_ack = 1'b0; irq_ret = 1'b0;
    chk("R8 ack wins over ret", int'(gie), 0);
    drain();

    // random mix of strobes, checked against model
    model_pend = '0;
    for (int it = 0; it < 60; it++) begin
      logic [3:0] fire;
      logic [7:0] en;
      int e;
      do_ack();
      fire = 4'($urandom_range(0, 15));
      busrst_evt = fire[0]; ep_evt = fire[3:1]; tick(1);
      busrst_evt = 1'b0; ep_evt = 3'b000;
      model_pend = model_pend | {2'b00, fire[3:1], 2'b00, fire[0]};
      en = 8'($urandom_range(0, 255));
      src_en = en;
      do_ret();
      e = exp_vec(model_pend & en);
      chk("R6 random vector", seen(), e);
      if (e >= 0) begin
        do_ack();
        model_pend[e/2] = 1'b0;
        chk("R7 random ack", int'(gie), 0);
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule